// File: doc/BRIEF.md
# BCD Real-Time Clock and Calendar

This block keeps wall-clock time (hours, minutes, seconds) and a calendar date (two-digit year, month, day) as packed BCD counters that advance without any binary-to-BCD conversion. It also tracks the day of the week and whether the current year is a leap year. Time can be read in 24-hour form, or in a 12-hour form where PM hours carry an extra 0x20. A sub-second prescaler, driven by a rate strobe from outside, advances the seconds and also produces a periodic tick at a selectable rate. An alarm fires when the counted time and date equal a programmed alarm time and date.

Software uses a flat, single-cycle register port. Each write is accepted in the cycle `reg_wr` is high. Reads are combinational from `reg_addr`. The port has no back-pressure because every access completes at once. Writes to configuration and counter registers are protected by two keys. A 32-bit start key brings the block out of its dormant state once. A 16-bit unlock key then opens a write window of limited length. Two interrupt lines report the alarm and the tick. Each has its own enable and a write-1-to-clear status flag.

Register map (word index on `reg_addr`): 0 start key, 1 unlock key, 2 time, 3 date, 4 hour mode, 5 weekday, 6 alarm time, 7 alarm date, 8 leap indicator, 9 interrupt enables, 10 status, 11 tick rate.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset, the registers read as follows: start key (0) reads 0, unlock key (1) reads 0, time (2) reads 0x000000, date (3) reads 0x050101, weekday (5) reads 6, status (10) reads 0, and both interrupt outputs are low.
- R2: Writing exactly 0xA5EB1357 to index 0 starts the block, and index 0 reads 1 from then on. Any other value written there has no effect. Until the block is started, the counters do not advance and the unlock key is refused.
- R3: Once the block is started, writing 0xA965 to bits 15:0 of index 1 opens a write window of WIN_CYCLES clock cycles (512 by default). Bit 16 of index 1 reads 1 while the window is open. Writes to indices 2–7, 9 and 11 are ignored while the window is closed. Writes to indices 0, 1 and 10 are never gated.
- R4: Time is packed as hour tens, hour units, minute tens, minute units, second tens and second units at bits 23:20, 19:16, 15:12, 11:8, 7:4 and 3:0. A write to index 2 made while the window is open loads the counter directly, coded in 24-hour form.
- R5: The seconds advance once every SUB_DIV pulses of `sub_pulse` (128 by default). Seconds and minutes roll over from 59 to 00, and hours roll over from 23 to 00, all in BCD.
- R6: The date is packed as year, month and day BCD bytes at bits 23:16, 15:8 and 7:0. The day rolls over to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months. Month 12 is followed by month 01 with the year incremented, and year 99 is followed by year 00.
- R7: A year is a leap year when its BCD value is divisible by 4 (00 counts as leap). In a leap year February rolls over after day 29, otherwise after day 28. Bit 0 of index 8 reads 1 in a leap year.
- R8: The weekday (index 5, bits 2:0, 0 to 6) advances by one each time the day rolls over, and wraps from 6 to 0.
- R9: When bit 0 of index 4 is 0 (12-hour mode), the hour byte of index 2 reads as follows: 24-hour 00 reads 0x12; 01–11 read unchanged; 12 reads 0x32; 13–23 read as the 12-hour value plus 0x20 (23 reads 0x31). When bit 0 of index 4 is 1 (reset value), the hour reads unchanged.
- R10: Status bit 0 (index 10) is set in the cycle after the counters step to a time and date equal to index 6 and index 7.
- R11: Status bit 1 is set once every SUB_DIV/2^n `sub_pulse` pulses, where n is bits 2:0 of index 11. With the default SUB_DIV this gives periods from 1 s (n=0) down to 1/128 s (n=7).
- R12: Writing 1 to a status bit clears that bit, and writing 0 leaves it unchanged. A set in the same cycle as a clear takes priority. `irq_alarm` equals status bit 0 AND enable bit 0 of index 9, and `irq_tick` equals status bit 1 AND enable bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the unit of the unlock window |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_pulse | input | 1 | One-cycle strobe at SUB_DIV times per second |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_alarm | output | 1 | Alarm interrupt, level |
| irq_tick | output | 1 | Periodic tick interrupt, level |

## Verification
A status clear written by software can land in the same cycle that the counters raise a flag. The tick flag is the one that makes this collision easy to reach. The bench selects the fastest tick rate, so every `sub_pulse` raises the flag. It then times a write-1-to-clear to land exactly in the cycle when the registered tick strobe is high. The bench then reads the status and expects the tick bit to be 1, because a set takes priority. A second clear issued with no pulse must leave the bit at 0. A separate case loads the time on the unlock path while seconds are counting. In that case the load must win over the step.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef struct packed {
    logic [7:0] hh;
    logic [7:0] mm;
    logic [7:0] ss;
  } rtc_time_t;

  typedef struct packed {
    logic [7:0] yy;
    logic [7:0] mo;
    logic [7:0] dd;
  } rtc_date_t;

  localparam logic [31:0] START_KEY  = 32'hA5EB_1357;
  localparam logic [15:0] UNLOCK_KEY = 16'hA965;

  typedef enum logic [3:0] {
    IX_START  = 4'd0,
    IX_UNLOCK = 4'd1,
    IX_TIME   = 4'd2,
    IX_DATE   = 4'd3,
    IX_MODE   = 4'd4,
    IX_WDAY   = 4'd5,
    IX_ATIME  = 4'd6,
    IX_ADATE  = 4'd7,
    IX_LEAP   = 4'd8,
    IX_IEN    = 4'd9,
    IX_STAT   = 4'd10,
    IX_TSEL   = 4'd11
  } rtc_index_e;

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
    return {v[7:4], v[3:0] + 4'd1};
  endfunction

  function automatic logic is_leap(input logic [7:0] yy);
    if (yy[4]) return (yy[3:0] == 4'd2) || (yy[3:0] == 4'd6);
    return (yy[3:0] == 4'd0) || (yy[3:0] == 4'd4) || (yy[3:0] == 4'd8);
  endfunction

  function automatic logic [7:0] last_day(input logic [7:0] mo, input logic leap);
    case (mo)
      8'h02:                      return leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
      default:                    return 8'h31;
    endcase
  endfunction

  function automatic logic [7:0] hour_12h(input logic [7:0] h);
    logic [4:0] b;
    logic [4:0] r;
    b = 5'(h[7:4]) * 5'd10 + 5'(h[3:0]);
    r = b - 5'd12;
    if (b == 5'd0) return 8'h12;
    if (b < 5'd12) return h;
    if (b == 5'd12) return 8'h32;
    if (r >= 5'd10) return {4'h3, 4'(r - 5'd10)};
    return {4'h2, r[3:0]};
  endfunction

endpackage

// File: rtl/rtc_key_gate.sv
module rtc_key_gate #(
  parameter int WIN_CYCLES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_wr,
  input  logic        unlock_wr,
  input  logic [31:0] wdata,
  output logic        started,
  output logic        win_open
);
  import rtc_pkg::*;

  localparam int CW = $clog2(WIN_CYCLES + 1);

  logic [CW-1:0] win_cnt;
  logic          key_hit;

  assign key_hit  = unlock_wr && started && (wdata[15:0] == UNLOCK_KEY);
  assign win_open = (win_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      win_cnt <= '0;
    end else begin
      if (start_wr && wdata == START_KEY) started <= 1'b1;
      if (key_hit)             win_cnt <= CW'(WIN_CYCLES);
      else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
    end
  end

  a_r3_open_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
    win_open |-> started);
  a_r3_open_from_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(win_open) |-> $past(unlock_wr && wdata[15:0] == UNLOCK_KEY));

endmodule

// File: rtl/rtc_timekeeper.sv
module rtc_timekeeper #(
  parameter int SUB_DIV = 128
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic                sub_pulse,
  input  logic [2:0]          tick_sel,
  input  logic                time_ld,
  input  logic                date_ld,
  input  logic                wday_ld,
  input  logic [23:0]         ld_data,
  output rtc_pkg::rtc_time_t  cur_time,
  output rtc_pkg::rtc_date_t  cur_date,
  output logic [2:0]          wday,
  output logic                adv,
  output logic                stepped,
  output logic                tick_stb
);
  import rtc_pkg::*;

  localparam int PW = $clog2(SUB_DIV);

  logic [PW-1:0] presc, presc_nx, tmask;
  rtc_time_t     nt;
  rtc_date_t     nd;
  logic          s_w, m_w, h_w, d_w, mo_w, day_c, mon_c;

  assign presc_nx = presc + 1'b1;
  assign tmask    = PW'((SUB_DIV >> tick_sel) - 1);
  assign adv      = run && sub_pulse && (presc == PW'(SUB_DIV - 1));

  always_comb begin
    s_w   = (cur_time.ss == 8'h59);
    m_w   = (cur_time.mm == 8'h59);
    h_w   = (cur_time.hh == 8'h23);
    d_w   = (cur_date.dd == last_day(cur_date.mo, is_leap(cur_date.yy)));
    mo_w  = (cur_date.mo == 8'h12);
    day_c = s_w && m_w && h_w;
    mon_c = day_c && d_w;
    nt.ss = s_w ? 8'h00 : bcd_inc(cur_time.ss);
    nt.mm = s_w ? (m_w ? 8'h00 : bcd_inc(cur_time.mm)) : cur_time.mm;
    nt.hh = (s_w && m_w) ? (h_w ? 8'h00 : bcd_inc(cur_time.hh)) : cur_time.hh;
    nd.dd = day_c ? (d_w ? 8'h01 : bcd_inc(cur_date.dd)) : cur_date.dd;
    nd.mo = mon_c ? (mo_w ? 8'h01 : bcd_inc(cur_date.mo)) : cur_date.mo;
    nd.yy = (mon_c && mo_w) ? ((cur_date.yy == 8'h99) ? 8'h00 : bcd_inc(cur_date.yy))
                            : cur_date.yy;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc    <= '0;
      cur_time <= '0;
      cur_date <= 24'h050101;
      wday     <= 3'd6;
      stepped  <= 1'b0;
      tick_stb <= 1'b0;
    end else begin
      if (run && sub_pulse) presc <= presc_nx;
      tick_stb <= run && sub_pulse && ((presc_nx & tmask) == '0);
      stepped  <= adv && !time_ld && !date_ld;
      if (time_ld)  cur_time <= ld_data;
      else if (adv) cur_time <= nt;
      if (date_ld)  cur_date <= ld_data;
      else if (adv) cur_date <= nd;
      if (wday_ld)           wday <= ld_data[2:0];
      else if (adv && day_c) wday <= (wday >= 3'd6) ? 3'd0 : wday + 3'd1;
    end
  end

  a_r5_step_moves_time: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !time_ld |=> cur_time != $past(cur_time));
  a_r2_idle_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !time_ld |=> $stable(cur_time));
  a_r8_wday_range: assert property (@(posedge clk) disable iff (!rst_n)
    !wday_ld && wday <= 3'd6 |=> wday <= 3'd6);

endmodule

// File: rtl/rtc_irq.sv
module rtc_irq (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stepped,
  input  logic               tick_stb,
  input  rtc_pkg::rtc_time_t cur_time,
  input  rtc_pkg::rtc_date_t cur_date,
  input  rtc_pkg::rtc_time_t alm_time,
  input  rtc_pkg::rtc_date_t alm_date,
  input  logic               clr_wr,
  input  logic [1:0]         clr_bits,
  input  logic [1:0]         irq_en,
  output logic [1:0]         flags,
  output logic               irq_alarm,
  output logic               irq_tick
);
  logic       hit;
  logic [1:0] clr;

  assign hit = stepped && (cur_time == alm_time) && (cur_date == alm_date);
  assign clr = clr_wr ? clr_bits : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= 2'b00;
    else begin
      flags[0] <= hit      | (flags[0] & ~clr[0]);
      flags[1] <= tick_stb | (flags[1] & ~clr[1]);
    end
  end

  assign irq_alarm = flags[0] & irq_en[0];
  assign irq_tick  = flags[1] & irq_en[1];

  a_r10_alarm_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[0]) |-> $past(stepped));
  a_r12_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    tick_stb |=> flags[1]);
  a_r12_clear_works: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && clr_bits[1] && !tick_stb |=> !flags[1]);

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar #(
  parameter int SUB_DIV    = 128,
  parameter int WIN_CYCLES = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sub_pulse,
  input  logic        reg_wr,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        irq_alarm,
  output logic        irq_tick
);
  import rtc_pkg::*;

  logic       started, win_open, gwr;
  logic       mode24;
  logic [1:0] irq_en, flags;
  logic [2:0] tick_sel, wday;
  logic       adv, stepped, tick_stb;
  rtc_time_t  cur_time, alm_time;
  rtc_date_t  cur_date, alm_date;

  assign gwr = reg_wr && win_open;

  rtc_key_gate #(.WIN_CYCLES(WIN_CYCLES)) u_gate (
    .clk(clk), .rst_n(rst_n),
    .start_wr (reg_wr && reg_addr == IX_START),
    .unlock_wr(reg_wr && reg_addr == IX_UNLOCK),
    .wdata(reg_wdata), .started(started), .win_open(win_open)
  );

  rtc_timekeeper #(.SUB_DIV(SUB_DIV)) u_keep (
    .clk(clk), .rst_n(rst_n), .run(started), .sub_pulse(sub_pulse),
    .tick_sel(tick_sel),
    .time_ld(gwr && reg_addr == IX_TIME),
    .date_ld(gwr && reg_addr == IX_DATE),
    .wday_ld(gwr && reg_addr == IX_WDAY),
    .ld_data(reg_wdata[23:0]),
    .cur_time(cur_time), .cur_date(cur_date), .wday(wday),
    .adv(adv), .stepped(stepped), .tick_stb(tick_stb)
  );

  rtc_irq u_irq (
    .clk(clk), .rst_n(rst_n), .stepped(stepped), .tick_stb(tick_stb),
    .cur_time(cur_time), .cur_date(cur_date),
    .alm_time(alm_time), .alm_date(alm_date),
    .clr_wr(reg_wr && reg_addr == IX_STAT), .clr_bits(reg_wdata[1:0]),
    .irq_en(irq_en), .flags(flags),
    .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode24   <= 1'b1;
      alm_time <= '0;
      alm_date <= '0;
      irq_en   <= 2'b00;
      tick_sel <= 3'd0;
    end else if (gwr) begin
      case (reg_addr)
        IX_MODE:  mode24   <= reg_wdata[0];
        IX_ATIME: alm_time <= reg_wdata[23:0];
        IX_ADATE: alm_date <= reg_wdata[23:0];
        IX_IEN:   irq_en   <= reg_wdata[1:0];
        IX_TSEL:  tick_sel <= reg_wdata[2:0];
        default:  ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      IX_START:  reg_rdata[0]     = started;
      IX_UNLOCK: reg_rdata[16]    = win_open;
      IX_TIME:   reg_rdata[23:0]  = {mode24 ? cur_time.hh : hour_12h(cur_time.hh),
                                     cur_time.mm, cur_time.ss};
      IX_DATE:   reg_rdata[23:0]  = cur_date;
      IX_MODE:   reg_rdata[0]     = mode24;
      IX_WDAY:   reg_rdata[2:0]   = wday;
      IX_ATIME:  reg_rdata[23:0]  = alm_time;
      IX_ADATE:  reg_rdata[23:0]  = alm_date;
      IX_LEAP:   reg_rdata[0]     = is_leap(cur_date.yy);
      IX_IEN:    reg_rdata[1:0]   = irq_en;
      IX_STAT:   reg_rdata[1:0]   = flags;
      IX_TSEL:   reg_rdata[2:0]   = tick_sel;
      default:   reg_rdata        = '0;
    endcase
  end

  a_r3_closed_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !win_open && reg_addr == IX_TIME && !adv |=> $stable(cur_time));
  a_r12_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    irq_tick |-> irq_en[1]);

endmodule

// File: tb/test_rtc_bcd_calendar.sv
module test_rtc_bcd_calendar;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sub_pulse = 1'b0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq_alarm, irq_tick;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  rtc_bcd_calendar i_rtc_bcd_calendar (
    .clk(clk), .rst_n(rst_n), .sub_pulse(sub_pulse),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_alarm(irq_alarm), .irq_tick(irq_tick)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); sub_pulse = 1'b1;
      @(negedge clk); sub_pulse = 1'b0;
    end
  endtask

  task automatic unlock();
    wr(4'd1, 32'h0000_A965);
  endtask

  // pulses until the time register changes, then returns the new time
  task automatic step_second(output logic [31:0] t);
    logic [31:0] t0;
    rd(4'd2, t0);
    t = t0;
    for (int i = 0; i < 140 && t == t0; i++) begin
      pulse(1);
      rd(4'd2, t);
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd0, d);  chk("R1 start reads 0", d, 0);
    rd(4'd1, d);  chk("R1 unlock reads 0", d, 0);
    rd(4'd2, d);  chk("R1 time reset", d, 32'h0);
    rd(4'd3, d);  chk("R1 date reset", d, 32'h050101);
    rd(4'd5, d);  chk("R1 weekday reset", d, 6);
    rd(4'd10, d); chk("R1 status reset", d, 0);
    chk("R1 irq lines low", {30'd0, irq_alarm, irq_tick}, 0);
  endtask

  task automatic t_start();
    logic [31:0] d;
    unlock();
    rd(4'd1, d);  chk("R2 unlock refused before start", d, 0);
    pulse(130);
    rd(4'd2, d);  chk("R2 no counting before start", d, 0);
    wr(4'd0, 32'hA5EB_1356);
    rd(4'd0, d);  chk("R2 wrong start key ignored", d, 0);
    wr(4'd0, 32'hA5EB_1357);
    rd(4'd0, d);  chk("R2 start key accepted", d, 1);
  endtask

  task automatic t_window();
    logic [31:0] d;
    wr(4'd2, 32'h0011_2233);
    rd(4'd2, d);  chk("R3 write without window ignored", d[23:0] == 24'h112233, 0);
    unlock();
    rd(4'd1, d);  chk("R3 window bit16 open", d, 32'h0001_0000);
    wr(4'd2, 32'h0009_3043);
    rd(4'd2, d);  chk("R4 time load", d, 32'h093043);
    repeat (520) @(negedge clk);
    rd(4'd1, d);  chk("R3 window closes", d, 0);
    wr(4'd3, 32'h0020_0101);
    rd(4'd3, d);  chk("R3 date write after close ignored", d, 32'h050101);
  endtask

  task automatic t_roll();
    logic [31:0] d;
    unlock();
    wr(4'd2, 32'h0023_5959); wr(4'd3, 32'h0012_0228); wr(4'd5, 6);
    rd(4'd8, d);  chk("R7 leap year 12", d, 1);
    step_second(d); chk("R5 time wraps midnight", d, 32'h000000);
    rd(4'd3, d);  chk("R7 Feb 28 to 29 in leap year", d, 32'h120229);
    rd(4'd5, d);  chk("R8 weekday 6 wraps to 0", d, 0);
    unlock();
    wr(4'd2, 32'h0023_5959); wr(4'd3, 32'h0013_0228);
    rd(4'd8, d);  chk("R7 year 13 not leap", d, 0);
    step_second(d);
    rd(4'd3, d);  chk("R7 Feb 28 to Mar 01", d, 32'h130301);
    rd(4'd5, d);  chk("R8 weekday increments", d, 1);
    unlock();
    wr(4'd2, 32'h0023_5959); wr(4'd3, 32'h0013_0430);
    step_second(d);
    rd(4'd3, d);  chk("R6 30-day month", d, 32'h130501);
    unlock();
    wr(4'd2, 32'h0023_5959); wr(4'd3, 32'h0099_1231);
    step_second(d); chk("R5 time after year end", d, 0);
    rd(4'd3, d);  chk("R6 year 99 wraps to 00", d, 32'h000101);
    rd(4'd8, d);  chk("R7 year 00 leap", d, 1);
    unlock();
    wr(4'd2, 32'h0010_5959);
    step_second(d); chk("R5 minute/hour carry", d, 32'h110000);
    step_second(d); chk("R5 second increments", d, 32'h110001);
  endtask

  task automatic t_12h();
    logic [31:0] d;
    unlock();
    wr(4'd4, 0);
    wr(4'd2, 32'h0000_0000); rd(4'd2, d); chk("R9 hour 00 reads 12", d[23:16], 8'h12);
    unlock();
    wr(4'd2, 32'h0012_0000); rd(4'd2, d); chk("R9 hour 12 reads 32", d[23:16], 8'h32);
    wr(4'd2, 32'h0023_0000); rd(4'd2, d); chk("R9 hour 23 reads 31", d[23:16], 8'h31);
    wr(4'd2, 32'h0009_3043); rd(4'd2, d); chk("R9 AM hour unchanged", d, 32'h093043);
    wr(4'd2, 32'h0022_1500); rd(4'd2, d); chk("R9 hour 22 reads 30", d, 32'h301500);
    wr(4'd4, 1);             rd(4'd2, d); chk("R9 24h mode raw", d, 32'h221500);
  endtask

  task automatic t_alarm();
    logic [31:0] d;
    unlock();
    wr(4'd3, 32'h0012_0229); wr(4'd2, 32'h0010_0004);
    wr(4'd6, 32'h0010_0005); wr(4'd7, 32'h0012_0229);
    wr(4'd9, 1); wr(4'd10, 3);
    step_second(d);
    rd(4'd10, d); chk("R10 alarm flag on match", d[0], 1);
    chk("R12 irq_alarm with enable", irq_alarm, 1);
    wr(4'd10, 2);
    rd(4'd10, d); chk("R12 clearing tick leaves alarm", d[0], 1);
    wr(4'd10, 1);
    rd(4'd10, d); chk("R12 alarm cleared", d[0], 0);
    step_second(d);
    rd(4'd10, d); chk("R10 no alarm on mismatch", d[0], 0);
  endtask

  task automatic t_tick();
    logic [31:0] d;
    int cnt;
    unlock();
    wr(4'd11, 2); wr(4'd9, 2); wr(4'd10, 3);
    cnt = 0;
    for (int i = 0; i < 128; i++) begin
      pulse(1);
      rd(4'd10, d);
      if (d[1]) begin cnt++; wr(4'd10, 2); end
    end
    chk("R11 tick sel 2 gives 4 per second", cnt, 4);
    unlock();
    wr(4'd11, 7); wr(4'd10, 3);
    cnt = 0;
    for (int i = 0; i < 10; i++) begin
      pulse(1);
      rd(4'd10, d);
      if (d[1]) begin cnt++; wr(4'd10, 2); end
    end
    chk("R11 tick sel 7 every pulse", cnt, 10);
    // collision: clear lands with the registered tick strobe
    @(negedge clk); sub_pulse = 1'b1;
    @(negedge clk); sub_pulse = 1'b0; reg_wr = 1'b1; reg_addr = 4'd10; reg_wdata = 2;
    @(negedge clk); reg_wr = 1'b0;
    rd(4'd10, d); chk("R12 set wins over clear", d[1], 1);
    chk("R12 irq_tick with enable", irq_tick, 1);
    wr(4'd10, 2);
    rd(4'd10, d); chk("R12 plain clear", d[1], 0);
    chk("R12 irq_tick low after clear", irq_tick, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_start();
    t_window();
    t_roll();
    t_12h();
    t_alarm();
    t_tick();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule